// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block picks the single pending interrupt level that should be presented to the processor. Each cycle it samples a vector of request lines, a vector of mask bits, the current in-service vector and a special-mask flag. It then decides whether any unmasked request outranks everything already being serviced. If one does, it raises an interrupt output and reports that level as a binary code.

Priority is arranged as a ring. A pointer names the level that currently ranks lowest, and the level after it ranks highest. When an end-of-service strobe arrives with automatic rotation enabled, the level named in the strobe becomes the lowest-ranked level. Equal-priority sources are therefore served in turn. Request latching, vector generation and cascading are left to the surrounding controller.

Top module: `irqr_top`

## Requirements
- R1: Out of reset, level 0 ranks highest and level 7 lowest, `irq_out` is 0 and `irq_lvl` is 0.
- R2: The inputs `irq_req`, `irq_mask`, `in_svc` and `spec_mask` are captured on each rising clock edge. `irq_out` and `irq_lvl` reflect the values captured at the most recent edge.
- R3: A request whose `irq_mask` bit is 1 never raises `irq_out` and is never reported on `irq_lvl`.
- R4: Among unmasked requests, the one nearest the highest-ranked level, walking up the ring from it, is reported. With the reset ordering, this is the lowest index.
- R5: An `in_svc` bit that is 1 inhibits requests at its own level and at every lower-ranked level. Requests ranked above it still raise `irq_out`.
- R6: With `spec_mask` = 1, an `in_svc` bit whose level is masked inhibits nothing.
- R7: With `spec_mask` = 0, a masked level's `in_svc` bit still inhibits its own level and all lower-ranked levels.
- R8: A clock edge with `svc_stb` = 1 and `rot_en` = 1 makes level `svc_lvl` the lowest-ranked level and level `svc_lvl`+1 (mod 8) the highest. This takes effect for the outputs following that same edge.
- R9: A clock edge with `svc_stb` = 1 and `rot_en` = 0 leaves the ring order unchanged.
- R10: When no unmasked request outranks the in-service state, `irq_out` is 0 and `irq_lvl` keeps the last level it reported.
- R11: When every level keeps requesting and each reported level is retired with a rotating strobe, eight consecutive grants visit all eight levels once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 8 | Request line per level |
| irq_mask | input | 8 | Mask bit per level, 1 = masked |
| in_svc | input | 8 | In-service bit per level |
| spec_mask | input | 1 | Special mask mode enable |
| rot_en | input | 1 | Automatic rotation enable |
| svc_stb | input | 1 | End-of-service strobe |
| svc_lvl | input | 3 | Level retired by the strobe |
| irq_out | output | 1 | Interrupt to the processor |
| irq_lvl | output | 3 | Binary code of the chosen level |

## Verification
The properties assume that `svc_lvl` is meaningful only in a cycle where `svc_stb` is high. They also assume that the in-service vector comes from a controller consistent with the reported level, although the ring-pointer checks do not depend on that. The stimulus changes inputs only on falling edges. During rotation runs it strobes exactly the level the resolver last granted, so the ring advances the way a real service sequence would. Separate directed steps cover masked in-service bits, both with and without special mask mode, from several pointer positions.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

   // Ring ordering variant selected at elaboration.
   typedef enum logic {
      ORDER_FIXED = 1'b0,
      ORDER_RING  = 1'b1
   } order_e;

   // Reset value of the lowest-priority pointer: the top index,
   // so that index 0 ranks first.
   function automatic int unsigned low_ptr_reset(input int unsigned n);
      return n - 1;
   endfunction

endpackage

// File: rtl/irqr_ring_rotate.sv
// Rotates a level vector so that output bit 0 is the level ranked highest,
// i.e. out[i] = in[(low_ptr + 1 + i) mod N].
module irqr_ring_rotate #(
   parameter int unsigned N = 8,
   parameter int unsigned W = $clog2(N)
) (
   input  logic [N-1:0] vec_in,
   input  logic [W-1:0] low_ptr,
   output logic [N-1:0] vec_out
);
   for (genvar gi = 0; gi < N; gi++) begin : g_tap
      logic [W-1:0] src;
      assign src         = W'(gi) + low_ptr + W'(1);
      assign vec_out[gi] = vec_in[src];
   end
endmodule

// File: rtl/irqr_first_set.sv
// Position of the lowest set bit, with a found flag.
module irqr_first_set #(
   parameter int unsigned N = 8,
   parameter int unsigned W = $clog2(N)
) (
   input  logic [N-1:0] vec,
   output logic [W-1:0] pos,
   output logic         found
);
   always_comb begin
      pos   = '0;
      found = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            pos   = W'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irqr_ptr_reg.sv
// Lowest-priority pointer. Ring variant moves on a rotating strobe;
// fixed variant is a constant.
module irqr_ptr_reg
   import irqr_pkg::*;
#(
   parameter int unsigned N     = 8,
   parameter int unsigned W     = $clog2(N),
   parameter order_e      ORDER = ORDER_RING
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rot_en,
   input  logic         svc_stb,
   input  logic [W-1:0] svc_lvl,
   output logic [W-1:0] low_ptr
);
   localparam logic [W-1:0] PTR_RST = W'(low_ptr_reset(N));

   if (ORDER == ORDER_RING) begin : g_ring
      logic [W-1:0] ptr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q <= PTR_RST;
         end else if (svc_stb && rot_en) begin
            ptr_q <= svc_lvl;
         end
      end
      assign low_ptr = ptr_q;
   end else begin : g_fixed
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, rot_en, svc_stb, svc_lvl};
      assign low_ptr   = PTR_RST;
   end
endmodule

// File: rtl/irqr_top.sv
module irqr_top
   import irqr_pkg::*;
#(
   parameter int unsigned N     = 8,
   parameter order_e      ORDER = ORDER_RING
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N-1:0]       irq_req,
   input  logic [N-1:0]       irq_mask,
   input  logic [N-1:0]       in_svc,
   input  logic               spec_mask,
   input  logic               rot_en,
   input  logic               svc_stb,
   input  logic [$clog2(N)-1:0] svc_lvl,
   output logic               irq_out,
   output logic [$clog2(N)-1:0] irq_lvl
);
   localparam int unsigned W = $clog2(N);

   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("irqr_top: N must be a power of two, at least 2");
   end

   // Captured inputs.
   logic [N-1:0] req_q, mask_q, isr_q;
   logic         smm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         mask_q <= '0;
         isr_q  <= '0;
         smm_q  <= 1'b0;
      end else begin
         req_q  <= irq_req;
         mask_q <= irq_mask;
         isr_q  <= in_svc;
         smm_q  <= spec_mask;
      end
   end

   logic [W-1:0] ptr_q;
   irqr_ptr_reg #(.N(N), .W(W), .ORDER(ORDER)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rot_en  (rot_en),
      .svc_stb (svc_stb),
      .svc_lvl (svc_lvl),
      .low_ptr (ptr_q)
   );

   // Candidates and blockers in absolute order.
   logic [N-1:0] cand_abs, blk_abs;
   assign cand_abs = req_q & ~mask_q;
   assign blk_abs  = smm_q ? (isr_q & ~mask_q) : isr_q;

   // Reorder so bit 0 is the highest-ranked level.
   logic [N-1:0] cand_rel, blk_rel;
   irqr_ring_rotate #(.N(N), .W(W)) u_rot_cand (
      .vec_in (cand_abs), .low_ptr (ptr_q), .vec_out (cand_rel)
   );
   irqr_ring_rotate #(.N(N), .W(W)) u_rot_blk (
      .vec_in (blk_abs), .low_ptr (ptr_q), .vec_out (blk_rel)
   );

   logic [W-1:0] cand_pos, blk_pos;
   logic         cand_any, blk_any;
   irqr_first_set #(.N(N), .W(W)) u_ff_cand (
      .vec (cand_rel), .pos (cand_pos), .found (cand_any)
   );
   irqr_first_set #(.N(N), .W(W)) u_ff_blk (
      .vec (blk_rel), .pos (blk_pos), .found (blk_any)
   );

   logic         win;
   logic [W-1:0] win_lvl;
   assign win     = cand_any && (!blk_any || (cand_pos < blk_pos));
   assign win_lvl = cand_pos + ptr_q + W'(1);

   // Hold register for the reported level.
   logic [W-1:0] lvl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else if (win) begin
         lvl_q <= win_lvl;
      end
   end

   assign irq_out = win;
   assign irq_lvl = win ? win_lvl : lvl_q;
endmodule

// File: rtl/irqr_check.sv
module irqr_check
   import irqr_pkg::*;
#(
   parameter int unsigned N     = 8,
   parameter order_e      ORDER = ORDER_RING
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 irq_out,
   input logic [$clog2(N)-1:0] irq_lvl,
   input logic [N-1:0]         req_q,
   input logic [N-1:0]         mask_q,
   input logic [N-1:0]         isr_q,
   input logic [$clog2(N)-1:0] ptr_q,
   input logic                 svc_stb,
   input logic                 rot_en,
   input logic [$clog2(N)-1:0] svc_lvl
);
   // R3: the reported level is an unmasked, captured request.
   p_masked_never_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (req_q[irq_lvl] && !mask_q[irq_lvl]));

   // R5: a level already in service is never granted again.
   p_svc_not_regranted_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> !isr_q[irq_lvl]);

   // R10: with no grant the level output keeps its value.
   p_lvl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_out |-> $stable(irq_lvl));

   if (ORDER == ORDER_RING) begin : g_ring_props
      // R8: a rotating strobe loads the pointer.
      p_rot_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (svc_stb && rot_en) |=> (ptr_q == $past(svc_lvl)));

      // R9: without a rotating strobe the pointer is kept.
      p_rot_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !(svc_stb && rot_en) |=> $stable(ptr_q));
   end
endmodule

bind irqr_top irqr_check #(.N(N), .ORDER(ORDER)) u_irqr_check (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_out (irq_out),
   .irq_lvl (irq_lvl),
   .req_q   (req_q),
   .mask_q  (mask_q),
   .isr_q   (isr_q),
   .ptr_q   (ptr_q),
   .svc_stb (svc_stb),
   .rot_en  (rot_en),
   .svc_lvl (svc_lvl)
);

// File: tb/test_irqr_top.sv
`timescale 1ns/1ps
module test_irqr_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_req = '0, irq_mask = '0, in_svc = '0;
   logic       spec_mask = 1'b0, rot_en = 1'b0, svc_stb = 1'b0;
   logic [2:0] svc_lvl = '0;
   logic       irq_out;
   logic [2:0] irq_lvl;

   always #4 clk = ~clk;   // 125 MHz

   irqr_top i_irqr_top (
      .clk (clk), .rst_n (rst_n), .irq_req (irq_req), .irq_mask (irq_mask),
      .in_svc (in_svc), .spec_mask (spec_mask), .rot_en (rot_en),
      .svc_stb (svc_stb), .svc_lvl (svc_lvl), .irq_out (irq_out), .irq_lvl (irq_lvl)
   );

   typedef struct {
      logic       irq;
      logic [2:0] lvl;
      string      tag;
   } exp_t;
   exp_t exp_q[$];

   int n_cmp = 0, n_bad = 0;
   logic [2:0] m_ptr = 3'd7;   // model: lowest-ranked level
   logic [2:0] m_lvl = 3'd0;   // model: last reported level
   logic       done = 1'b0;

   // Driver: drive on a falling edge, predict the outputs after the next rise.
   task automatic apply(input logic [7:0] rq, input logic [7:0] mk, input logic [7:0] is,
                        input logic sm, input logic ro, input logic st,
                        input logic [2:0] sl, input string tag);
      exp_t e;
      @(negedge clk);
      irq_req = rq; irq_mask = mk; in_svc = is; spec_mask = sm;
      rot_en = ro; svc_stb = st; svc_lvl = sl;
      if (st && ro) m_ptr = sl;
      e.irq = 1'b0;
      e.lvl = m_lvl;
      e.tag = tag;
      for (int k = 1; k <= 8; k++) begin
         logic [2:0] lv;
         lv = m_ptr + 3'(k);
         if (is[lv] && !(sm && mk[lv])) break;
         if (rq[lv] && !mk[lv]) begin
            e.irq = 1'b1;
            e.lvl = lv;
            break;
         end
      end
      m_lvl = e.lvl;
      exp_q.push_back(e);
   endtask

   // Monitor: compare after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #3;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (irq_out !== e.irq || irq_lvl !== e.lvl) begin
               n_bad++;
               $display("FAIL %s: got irq=%0b lvl=%0d, expected irq=%0b lvl=%0d",
                        e.tag, irq_out, irq_lvl, e.irq, e.lvl);
            end
         end
      end
   end

   // Watchdog.
   initial begin
      #100000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_cmp++;
      if (irq_out !== 1'b0 || irq_lvl !== 3'd0) begin
         n_bad++;
         $display("FAIL R1 reset: got irq=%0b lvl=%0d, expected irq=0 lvl=0", irq_out, irq_lvl);
      end
      rst_n = 1'b1;

      apply(8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R1 idle after reset");
      // R4 / R2: fixed reset order, outputs one edge after inputs.
      apply(8'hFF, 8'h00, 8'h00, 0, 0, 0, 0, "R4 all request");
      apply(8'h88, 8'h00, 8'h00, 0, 0, 0, 0, "R4 levels 3,7");
      apply(8'h80, 8'h00, 8'h00, 0, 0, 0, 0, "R2 R4 only 7");
      // R3 masking, R10 hold.
      apply(8'h0F, 8'h03, 8'h00, 0, 0, 0, 0, "R3 low two masked");
      apply(8'h01, 8'h01, 8'h00, 0, 0, 0, 0, "R3 R10 only masked");
      apply(8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R10 nothing pending");
      // R5 in-service blocking.
      apply(8'h30, 8'h00, 8'h08, 0, 0, 0, 0, "R5 lower blocked");
      apply(8'h04, 8'h00, 8'h08, 0, 0, 0, 0, "R5 higher passes");
      apply(8'h08, 8'h00, 8'h08, 0, 0, 0, 0, "R5 same level blocked");
      // R6 / R7 special mask mode.
      apply(8'h10, 8'h02, 8'h02, 1, 0, 0, 0, "R6 masked isr ignored");
      apply(8'h10, 8'h02, 8'h02, 0, 0, 0, 0, "R7 masked isr blocks");
      apply(8'h10, 8'h00, 8'h02, 1, 0, 0, 0, "R6 unmasked isr blocks");
      // R8 rotation to pointer 3.
      apply(8'h00, 8'h00, 8'h00, 0, 1, 1, 3'd3, "R8 strobe level 3");
      apply(8'hFF, 8'h00, 8'h00, 0, 1, 0, 0, "R8 level 4 first");
      apply(8'h09, 8'h00, 8'h00, 0, 1, 0, 0, "R8 0 beats 3");
      apply(8'h41, 8'h00, 8'h20, 0, 1, 0, 0, "R8 R5 isr 5 blocks wrap");
      apply(8'h11, 8'h00, 8'h20, 0, 1, 0, 0, "R8 R5 4 above 5");
      apply(8'h11, 8'h01, 8'h10, 1, 1, 0, 0, "R8 R6 rotated smm");
      // R9 strobe without rotation.
      apply(8'h00, 8'h00, 8'h00, 0, 0, 1, 3'd6, "R9 strobe no rotate");
      apply(8'h11, 8'h00, 8'h00, 0, 0, 0, 0, "R9 order kept");
      // R8 rotation and strobe in the same cycle as requests.
      apply(8'h11, 8'h00, 8'h00, 0, 1, 1, 3'd6, "R8 same-edge rotate");
      // R11 fairness: retire every grant with a rotating strobe.
      for (int c = 0; c < 16; c++) begin
         apply(8'hFF, 8'h00, 8'h00, 0, 1, c > 0, m_lvl, "R11 round robin");
      end
      apply(8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R10 drain");

      repeat (4) @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule